// File: doc/BRIEF.md
# Host UART Frame Handler with Automatic Baud Detection

This block is the device end of a serial host link. The host sends a frame made of a start-of-frame marker byte, a length byte and a payload. The block unwraps these frames and delivers only the payload bytes to a valid/ready byte stream, with a flag on the last byte of each frame. For the way back, a client asks the block to send a response by giving a length. The block sends that length byte and then pulls the announced number of data bytes from a second byte stream. A length of zero sends the single acknowledge byte used for transactions that return no data. The client may start a response at any time, unprompted.

After reset the block does not know the line rate. It measures the start bit of the first marker byte the host sends. It then picks whichever of two allowed rates (one slow, one fast, each given as clocks per bit) lies closer, and treats that byte as the marker of the first frame. Flow control runs in both directions. A request-to-send output tells the host to pause before the receive buffer overflows. A clear-to-send input holds back the transmitter. Each of these two lines has its own programmable polarity. The transmitter can append a second stop bit.

Top module: `hostlink_uart`

## Requirements
- R1: After reset `baud_locked` is 0. The low time of the first start bit is measured and snapped to the nearer of BIT_FAST and BIT_SLOW clocks per bit. `baud_fast` is 1 for the fast rate. `baud_locked` rises in the middle of that byte's stop bit, and the byte counts as the marker of the first frame.
- R2: Serial format is one start bit (0), 8 data bits LSB first, no parity, a stop bit (1). A frame is the marker 0x55, a length byte L, then L payload bytes. The payload bytes appear on `rxd_data` in order, and `rxd_last` is 1 only on the final byte.
- R3: A length byte of 0x00 announces 256 payload bytes.
- R4: While waiting for a marker, any received byte other than 0x55 is dropped and never appears on the stream.
- R5: Inside a frame (after the marker, before the last payload byte), suppose no byte completes within `cfg_gap_limit` clocks of the previous one. Then `frm_err` pulses for one cycle and the block waits for a new marker. Bytes already delivered are kept. A limit of 0 disables the check.
- R6: While `rxd_valid` is 1 and `rxd_ready` is 0, `rxd_valid`, `rxd_data` and `rxd_last` hold.
- R7: The request-to-send line is active while the receive buffer (FIFO_DEPTH entries) holds fewer than FIFO_DEPTH-1 bytes. It is inactive once only one free entry is left. Its pin level is the active state XOR `cfg_rts_low` (1 = active-low).
- R8: A `tx_start` pulse with `tx_len` from 1 to 255 sends a byte equal to `tx_len`, then exactly `tx_len` bytes taken in order from the `rsp_data` stream.
- R9: A `tx_start` pulse with `tx_len` = 0 sends the single byte 0x00 and takes nothing from the response stream.
- R10: No start bit begins while clear-to-send is inactive. The input is active when the pin equals NOT `cfg_cts_low`. A byte already started is completed.
- R11: With `cfg_stop2` = 0, consecutive response bytes start 10 bit times apart (plus at most a few clocks). With `cfg_stop2` = 1 the spacing is 11 bit times.
- R12: Once set, `baud_locked` and `baud_fast` keep their values until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_stop2 | input | 1 | Transmit two stop bits |
| cfg_rts_low | input | 1 | Request-to-send pin is active-low |
| cfg_cts_low | input | 1 | Clear-to-send pin is active-low |
| cfg_gap_limit | input | GAP_W | Inter-byte timeout in clocks, 0 disables |
| uart_rx | input | 1 | Serial line from host |
| uart_tx | output | 1 | Serial line to host |
| uart_rts | output | 1 | Flow-control output to host |
| uart_cts | input | 1 | Flow-control input from host |
| rxd_data | output | 8 | Received payload byte |
| rxd_last | output | 1 | Byte is the last of its frame |
| rxd_valid | output | 1 | Payload byte available |
| rxd_ready | input | 1 | Consumer takes the byte |
| frm_err | output | 1 | One-cycle pulse on inter-byte timeout |
| baud_locked | output | 1 | Rate detection finished |
| baud_fast | output | 1 | Detected rate is the fast one |
| tx_start | input | 1 | Start a response |
| tx_len | input | 8 | Response length, 0 = acknowledge |
| tx_busy | output | 1 | Response in progress |
| rsp_data | input | 8 | Response data byte |
| rsp_valid | input | 1 | Response byte available |
| rsp_ready | output | 1 | Response byte taken |

## Verification
Each received payload byte is sampled in the middle of its stop bit. It reaches the stream about three clocks after the serial input settles there, because of the two-flop synchronizer, the sampler register and the buffer write. The bench therefore checks buffer-dependent outputs such as request-to-send only after it has driven the whole stop bit, which is half a bit time later. The stream itself is checked in a model process at the handshake point of every clock. The rate lock is due at mid-stop of the first marker, and the bench checks it a few clocks after that byte ends. A response start bit begins one clock after launch. The bench decodes the serial output at mid-bit and compares start-bit spacing against a window of 10 or 11 bit times plus four clocks. The timeout pulse is expected `cfg_gap_limit`+1 clocks after the last completed byte, so the bench waits well past that point before it counts pulses.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
  localparam logic [7:0] SOF_BYTE = 8'h55;
  localparam logic [7:0] ACK_BYTE = 8'h00;

  typedef enum logic [1:0] {RX_HUNT, RX_LEN, RX_BODY} rxfrm_e;
  typedef enum logic [1:0] {TX_IDLE, TX_HDR, TX_BODY, TX_DRAIN} txfrm_e;

  // nearer of the two permitted bit times
  function automatic logic pick_fast(input int width, input int slow, input int fast);
    return (2 * width) < (slow + fast);
  endfunction

  // length byte to payload count, zero meaning the full 256
  function automatic logic [8:0] payload_len(input logic [7:0] lb);
    return (lb == 8'h00) ? 9'd256 : {1'b0, lb};
  endfunction

  // logical state to pin level under a polarity select
  function automatic logic pin_level(input logic active, input logic act_low);
    return active ^ act_low;
  endfunction
endpackage

// File: rtl/hl_autobaud.sv
module hl_autobaud #(
  parameter int BIT_SLOW = 96,
  parameter int BIT_FAST = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_s,
  output logic locked,
  output logic fast,
  output logic lock_pulse
);
  import hostlink_pkg::*;
  localparam int CW = $clog2(9 * BIT_SLOW + 1);
  localparam logic [CW-1:0] SKIP_S  = CW'(8 * BIT_SLOW + BIT_SLOW / 2 - 1);
  localparam logic [CW-1:0] SKIP_F  = CW'(8 * BIT_FAST + BIT_FAST / 2 - 1);
  localparam logic [CW-1:0] MEASMAX = CW'(2 * BIT_SLOW);
  localparam logic [CW-1:0] GLITCH  = CW'(BIT_FAST / 2);

  typedef enum logic [2:0] {AB_ARM, AB_WAIT, AB_MEAS, AB_SKIP, AB_DONE} ab_e;
  ab_e st;
  logic [CW-1:0] cnt;
  logic fast_q;
  logic [CW-1:0] skip_end;

  assign skip_end = fast_q ? SKIP_F : SKIP_S;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= AB_ARM;
      cnt <= '0;
      fast_q <= 1'b0;
      lock_pulse <= 1'b0;
    end else begin
      lock_pulse <= 1'b0;
      unique case (st)
        AB_ARM: if (rx_s) st <= AB_WAIT;
        AB_WAIT: if (!rx_s) begin
          st <= AB_MEAS;
          cnt <= CW'(1);
        end
        AB_MEAS: begin
          if (rx_s) begin
            if (cnt < GLITCH) begin
              st <= AB_WAIT;
            end else begin
              fast_q <= pick_fast(32'(cnt), BIT_SLOW, BIT_FAST);
              st <= AB_SKIP;
              cnt <= '0;
            end
          end else if (cnt == MEASMAX) begin
            st <= AB_ARM;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        AB_SKIP: begin
          if (cnt == skip_end) begin
            st <= AB_DONE;
            lock_pulse <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= AB_DONE;
      endcase
    end
  end

  assign locked = (st == AB_DONE);
  assign fast = fast_q;
endmodule

// File: rtl/hl_uart_rx.sv
module hl_uart_rx #(
  parameter int BIT_SLOW = 96,
  parameter int BIT_FAST = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       fast,
  input  logic       rx_s,
  output logic       byte_stb,
  output logic [7:0] byte_q
);
  localparam int CW = $clog2(BIT_SLOW + 1);
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rxs_e;
  rxs_e st;
  logic [CW-1:0] cnt, per, half;
  logic [2:0] nbit;
  logic [7:0] sh;

  assign per  = fast ? CW'(BIT_FAST) : CW'(BIT_SLOW);
  assign half = per >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      nbit <= '0;
      sh <= '0;
      byte_stb <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      unique case (st)
        S_IDLE: if (en && !rx_s) begin
          st <= S_START;
          cnt <= '0;
        end
        S_START: begin
          if (cnt == half - 1'b1) begin
            st <= rx_s ? S_IDLE : S_DATA;
            cnt <= '0;
            nbit <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt == per - 1'b1) begin
            cnt <= '0;
            sh <= {rx_s, sh[7:1]};
            if (nbit == 3'd7) st <= S_STOP;
            else nbit <= nbit + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == per - 1'b1) begin
            byte_stb <= rx_s;
            st <= S_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign byte_q = sh;
endmodule

// File: rtl/hl_uart_tx.sv
module hl_uart_tx #(
  parameter int BIT_SLOW = 96,
  parameter int BIT_FAST = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast,
  input  logic       stop2,
  input  logic       cts_ok,
  input  logic       go,
  input  logic [7:0] din,
  output logic       rdy,
  output logic       idle,
  output logic       txd
);
  localparam int CW = $clog2(BIT_SLOW + 1);
  logic busy;
  logic [10:0] sh;
  logic [3:0] left;
  logic [CW-1:0] cnt, per;

  assign per  = fast ? CW'(BIT_FAST) : CW'(BIT_SLOW);
  assign idle = !busy;
  assign rdy  = !busy && cts_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh <= '1;
      left <= '0;
      cnt <= '0;
      txd <= 1'b1;
    end else if (!busy) begin
      if (go && rdy) begin
        sh <= {2'b11, din, 1'b0};
        left <= stop2 ? 4'd11 : 4'd10;
        cnt <= '0;
        busy <= 1'b1;
        txd <= 1'b0;
      end
    end else if (cnt == per - 1'b1) begin
      cnt <= '0;
      sh <= {1'b1, sh[10:1]};
      left <= left - 1'b1;
      if (left == 4'd1) begin
        busy <= 1'b0;
        txd <= 1'b1;
      end else begin
        txd <= sh[1];
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hl_rx_fifo.sv
module hl_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int W = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [W-1:0]           wdata,
  input  logic                   pop,
  output logic [W-1:0]           rdata,
  output logic                   empty,
  output logic [$clog2(DEPTH):0] occ
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULLCNT = (AW + 1)'(DEPTH);
  localparam logic [AW-1:0] LASTPTR = AW'(DEPTH - 1);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] cnt;
  logic do_push, do_pop;

  assign do_push = push && (cnt != FULLCNT);
  assign do_pop  = pop && (cnt != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LASTPTR) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LASTPTR) ? '0 : rp + 1'b1;
      cnt <= cnt + (do_push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
    end
  end

  assign rdata = mem[rp];
  assign empty = (cnt == '0);
  assign occ   = cnt;
endmodule

// File: rtl/hostlink_uart.sv
module hostlink_uart #(
  parameter int BIT_SLOW   = 96,
  parameter int BIT_FAST   = 12,
  parameter int FIFO_DEPTH = 4,
  parameter int GAP_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_stop2,
  input  logic             cfg_rts_low,
  input  logic             cfg_cts_low,
  input  logic [GAP_W-1:0] cfg_gap_limit,
  input  logic             uart_rx,
  output logic             uart_tx,
  output logic             uart_rts,
  input  logic             uart_cts,
  output logic [7:0]       rxd_data,
  output logic             rxd_last,
  output logic             rxd_valid,
  input  logic             rxd_ready,
  output logic             frm_err,
  output logic             baud_locked,
  output logic             baud_fast,
  input  logic             tx_start,
  input  logic [7:0]       tx_len,
  output logic             tx_busy,
  input  logic [7:0]       rsp_data,
  input  logic             rsp_valid,
  output logic             rsp_ready
);
  import hostlink_pkg::*;
  localparam int OW = $clog2(FIFO_DEPTH) + 1;
  localparam logic [OW-1:0] RTS_LIMIT = OW'(FIFO_DEPTH - 1);

  // input synchronizers
  logic [1:0] rx_sync, cts_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync <= 2'b11;
      cts_sync <= 2'b00;
    end else begin
      rx_sync <= {rx_sync[0], uart_rx};
      cts_sync <= {cts_sync[0], uart_cts};
    end
  end
  logic rx_s, cts_ok;
  assign rx_s = rx_sync[1];
  assign cts_ok = pin_level(cts_sync[1], cfg_cts_low);

  // rate detection and byte receiver
  logic ab_lock;
  logic rx_stb;
  logic [7:0] rx_byte;

  hl_autobaud #(.BIT_SLOW(BIT_SLOW), .BIT_FAST(BIT_FAST)) u_ab (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s),
    .locked(baud_locked), .fast(baud_fast), .lock_pulse(ab_lock)
  );

  hl_uart_rx #(.BIT_SLOW(BIT_SLOW), .BIT_FAST(BIT_FAST)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(baud_locked), .fast(baud_fast), .rx_s(rx_s),
    .byte_stb(rx_stb), .byte_q(rx_byte)
  );

  // receive framer
  rxfrm_e rx_st;
  logic [8:0] remain;
  logic [GAP_W-1:0] gap;
  logic gap_hit, in_frame, fifo_push;

  assign gap_hit  = (cfg_gap_limit != '0) && (gap == cfg_gap_limit);
  assign in_frame = (rx_st != RX_HUNT);
  assign fifo_push = (rx_st == RX_BODY) && rx_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st <= RX_HUNT;
      remain <= '0;
      gap <= '0;
      frm_err <= 1'b0;
    end else begin
      frm_err <= 1'b0;
      unique case (rx_st)
        RX_HUNT: begin
          gap <= '0;
          if (ab_lock || (rx_stb && rx_byte == SOF_BYTE)) rx_st <= RX_LEN;
        end
        RX_LEN: begin
          if (rx_stb) begin
            remain <= payload_len(rx_byte);
            gap <= '0;
            rx_st <= RX_BODY;
          end else if (gap_hit) begin
            frm_err <= 1'b1;
            rx_st <= RX_HUNT;
          end else begin
            gap <= gap + 1'b1;
          end
        end
        RX_BODY: begin
          if (rx_stb) begin
            remain <= remain - 1'b1;
            gap <= '0;
            if (remain == 9'd1) rx_st <= RX_HUNT;
          end else if (gap_hit) begin
            frm_err <= 1'b1;
            rx_st <= RX_HUNT;
          end else begin
            gap <= gap + 1'b1;
          end
        end
        default: rx_st <= RX_HUNT;
      endcase
    end
  end

  // receive buffer and back-pressure
  logic [8:0] fifo_out;
  logic fifo_empty;
  logic [OW-1:0] rx_occ;

  hl_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(9)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(fifo_push), .wdata({remain == 9'd1, rx_byte}),
    .pop(rxd_valid && rxd_ready), .rdata(fifo_out),
    .empty(fifo_empty), .occ(rx_occ)
  );

  assign rxd_valid = !fifo_empty;
  assign rxd_data  = fifo_out[7:0];
  assign rxd_last  = fifo_out[8];
  assign uart_rts  = pin_level(rx_occ < RTS_LIMIT, cfg_rts_low);

  // response framer
  txfrm_e tx_st;
  logic [7:0] tx_left;
  logic ser_rdy, ser_idle, tx_launch;
  logic [7:0] ser_din;

  always_comb begin
    tx_launch = 1'b0;
    rsp_ready = 1'b0;
    ser_din = rsp_data;
    unique case (tx_st)
      TX_HDR: begin
        tx_launch = ser_rdy;
        ser_din = (tx_left == 8'd0) ? ACK_BYTE : tx_left;
      end
      TX_BODY: begin
        tx_launch = ser_rdy && rsp_valid;
        rsp_ready = tx_launch;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_st <= TX_IDLE;
      tx_left <= '0;
    end else begin
      unique case (tx_st)
        TX_IDLE: if (tx_start) begin
          tx_left <= tx_len;
          tx_st <= TX_HDR;
        end
        TX_HDR: if (tx_launch) tx_st <= (tx_left == 8'd0) ? TX_DRAIN : TX_BODY;
        TX_BODY: if (tx_launch) begin
          tx_left <= tx_left - 1'b1;
          if (tx_left == 8'd1) tx_st <= TX_DRAIN;
        end
        default: if (ser_idle) tx_st <= TX_IDLE;
      endcase
    end
  end

  assign tx_busy = (tx_st != TX_IDLE);

  hl_uart_tx #(.BIT_SLOW(BIT_SLOW), .BIT_FAST(BIT_FAST)) u_tx (
    .clk(clk), .rst_n(rst_n), .fast(baud_fast), .stop2(cfg_stop2),
    .cts_ok(cts_ok), .go(tx_launch), .din(ser_din),
    .rdy(ser_rdy), .idle(ser_idle), .txd(uart_tx)
  );
endmodule

// File: rtl/hostlink_uart_chk.sv
module hostlink_uart_chk #(
  parameter int DEPTH = 4,
  parameter int OW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [OW-1:0] rx_occ,
  input logic          uart_rts,
  input logic          cfg_rts_low,
  input logic          tx_launch,
  input logic          cts_ok,
  input logic          rxd_valid,
  input logic          rxd_ready,
  input logic [7:0]    rxd_data,
  input logic          rxd_last,
  input logic          frm_err,
  input logic          in_frame,
  input logic          baud_locked,
  input logic          baud_fast
);
  AST_RTS_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rx_occ) >= DEPTH - 1) |-> (uart_rts == cfg_rts_low)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_occ) <= DEPTH); // R7
  AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_launch |-> cts_ok); // R10
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_valid && !rxd_ready) |=> (rxd_valid && $stable(rxd_data) && $stable(rxd_last))); // R6
  AST_ERR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_err) |-> $past(in_frame)); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    baud_locked |=> (baud_locked && $stable(baud_fast))); // R12
endmodule

bind hostlink_uart hostlink_uart_chk #(.DEPTH(FIFO_DEPTH), .OW($clog2(FIFO_DEPTH) + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_occ(rx_occ), .uart_rts(uart_rts),
  .cfg_rts_low(cfg_rts_low), .tx_launch(tx_launch), .cts_ok(cts_ok),
  .rxd_valid(rxd_valid), .rxd_ready(rxd_ready), .rxd_data(rxd_data),
  .rxd_last(rxd_last), .frm_err(frm_err), .in_frame(in_frame),
  .baud_locked(baud_locked), .baud_fast(baud_fast)
);

// File: tb/hostlink_uart_test.sv
`timescale 1ns/1ps
module hostlink_uart_test;
  localparam int PS = 96;
  localparam int PF = 12;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_stop2 = 1'b0, cfg_rts_low = 1'b0, cfg_cts_low = 1'b0;
  logic [15:0] cfg_gap_limit = 16'd2000;
  logic uart_rx = 1'b1, uart_cts = 1'b1;
  logic uart_tx, uart_rts;
  logic [7:0] rxd_data;
  logic rxd_last, rxd_valid, frm_err, baud_locked, baud_fast, tx_busy, rsp_ready;
  logic rxd_ready = 1'b1;
  logic tx_start = 1'b0;
  logic [7:0] tx_len = 8'd0;
  logic rsp_valid = 1'b1;
  logic [7:0] rsp_idx = 8'd0;
  logic [7:0] rsp_data;
  assign rsp_data = 8'hC0 + rsp_idx;

  always #4 clk = ~clk;

  hostlink_uart #(.BIT_SLOW(PS), .BIT_FAST(PF), .FIFO_DEPTH(DEPTH), .GAP_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_stop2(cfg_stop2), .cfg_rts_low(cfg_rts_low),
    .cfg_cts_low(cfg_cts_low), .cfg_gap_limit(cfg_gap_limit), .uart_rx(uart_rx),
    .uart_tx(uart_tx), .uart_rts(uart_rts), .uart_cts(uart_cts), .rxd_data(rxd_data),
    .rxd_last(rxd_last), .rxd_valid(rxd_valid), .rxd_ready(rxd_ready), .frm_err(frm_err),
    .baud_locked(baud_locked), .baud_fast(baud_fast), .tx_start(tx_start), .tx_len(tx_len),
    .tx_busy(tx_busy), .rsp_data(rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready)
  );

  int vectors = 0, miscomp = 0;
  int cyc = 0, err_seen = 0, tx_low = 0;
  int tx_p = PF;
  logic [8:0] exp_q[$];
  logic [7:0] got_tx[$];
  int got_cyc[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rsp_valid && rsp_ready) rsp_idx <= rsp_idx + 8'd1;
  end

  // stream model: compare every transfer against the expected queue
  always @(negedge clk) begin
    #1;
    if (frm_err) err_seen++;
    if (!uart_tx) tx_low++;
    if (rxd_valid && rxd_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected stream byte", {rxd_last, rxd_data}, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({rxd_last, rxd_data} == e, "R2 stream byte", {rxd_last, rxd_data}, e);
      end
    end
  end

  // serial decoder for the response line
  initial begin
    forever begin
      int fc;
      logic [7:0] b;
      @(negedge uart_tx);
      fc = cyc;
      repeat (tx_p / 2) @(negedge clk);
      if (uart_tx == 1'b0) begin
        b = '0;
        for (int i = 0; i < 8; i++) begin
          repeat (tx_p) @(negedge clk);
          b[i] = uart_tx;
        end
        repeat (tx_p) @(negedge clk);
        got_tx.push_back(b);
        got_cyc.push_back(fc);
      end
    end
  end

  task automatic host_byte(input logic [7:0] b, input int p);
    uart_rx = 1'b0;
    repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      uart_rx = b[i];
      repeat (p) @(negedge clk);
    end
    uart_rx = 1'b1;
    repeat (p) @(negedge clk);
  endtask

  task automatic expect_rx(input logic last, input logic [7:0] d);
    exp_q.push_back({last, d});
  endtask

  task automatic start_rsp(input logic [7:0] len);
    got_tx.delete();
    got_cyc.delete();
    tx_len = len;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  task automatic wait_tx(input int n, input int limit);
    for (int i = 0; i < limit && got_tx.size() < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    int e0, lows;
    do_reset();
    // reset state
    chk(uart_tx == 1'b1, "R8 idle line high after reset", uart_tx, 1);
    chk(baud_locked == 1'b0, "R1 unlocked after reset", baud_locked, 0);
    chk(rxd_valid == 1'b0, "R2 stream empty after reset", rxd_valid, 0);
    chk(uart_rts == 1'b1, "R7 rts active after reset", uart_rts, 1);

    // fast autobaud, marker doubles as first frame start
    host_byte(8'h55, PF);
    repeat (4) @(negedge clk);
    chk(baud_locked == 1'b1, "R1 locked", baud_locked, 1);
    chk(baud_fast == 1'b1, "R1 fast rate chosen", baud_fast, 1);
    expect_rx(0, 8'hA1); expect_rx(0, 8'hB2); expect_rx(1, 8'hC3);
    host_byte(8'h03, PF); host_byte(8'hA1, PF); host_byte(8'hB2, PF); host_byte(8'hC3, PF);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R2 first frame delivered", exp_q.size(), 0);

    // junk before marker
    expect_rx(1, 8'h77);
    host_byte(8'h12, PF); host_byte(8'h34, PF);
    host_byte(8'h55, PF); host_byte(8'h01, PF); host_byte(8'h77, PF);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4 junk discarded", exp_q.size(), 0);

    // data response
    rsp_idx = 8'd0;
    start_rsp(8'd2);
    wait_tx(3, 80 * PF);
    chk(got_tx.size() == 3, "R8 response byte count", got_tx.size(), 3);
    if (got_tx.size() == 3) begin
      chk(got_tx[0] == 8'h02, "R8 length byte", got_tx[0], 8'h02);
      chk(got_tx[1] == 8'hC0, "R8 data byte 0", got_tx[1], 8'hC0);
      chk(got_tx[2] == 8'hC1, "R8 data byte 1", got_tx[2], 8'hC1);
      e0 = got_cyc[1] - got_cyc[0];
      chk(e0 >= 10 * PF && e0 <= 10 * PF + 4, "R11 one stop spacing", e0, 10 * PF);
    end
    repeat (4 * PF) @(negedge clk);
    chk(tx_busy == 1'b0, "R8 response finished", tx_busy, 0);

    // acknowledge
    rsp_idx = 8'd0;
    start_rsp(8'd0);
    wait_tx(2, 40 * PF);
    chk(got_tx.size() == 1, "R9 single ack byte", got_tx.size(), 1);
    if (got_tx.size() >= 1) chk(got_tx[0] == 8'h00, "R9 ack value", got_tx[0], 0);
    chk(rsp_idx == 8'd0, "R9 no response data taken", rsp_idx, 0);

    // two stop bits
    cfg_stop2 = 1'b1;
    start_rsp(8'd2);
    wait_tx(3, 80 * PF);
    chk(got_tx.size() == 3, "R11 stop2 byte count", got_tx.size(), 3);
    if (got_tx.size() == 3) begin
      e0 = got_cyc[2] - got_cyc[1];
      chk(e0 >= 11 * PF && e0 <= 11 * PF + 4, "R11 two stop spacing", e0, 11 * PF);
      chk(got_tx[1] == 8'hC0, "R11 stop2 data", got_tx[1], 8'hC0);
    end
    cfg_stop2 = 1'b0;
    repeat (4 * PF) @(negedge clk);

    // clear-to-send gating and polarity
    uart_cts = 1'b0;
    repeat (4) @(negedge clk);
    lows = tx_low;
    start_rsp(8'd0);
    repeat (40 * PF) @(negedge clk);
    chk(tx_low == lows, "R10 line quiet while cts inactive", tx_low - lows, 0);
    chk(got_tx.size() == 0, "R10 nothing sent while cts inactive", got_tx.size(), 0);
    cfg_cts_low = 1'b1;
    wait_tx(1, 40 * PF);
    chk(got_tx.size() == 1, "R10 sent once active-low cts asserted", got_tx.size(), 1);
    uart_cts = 1'b1; cfg_cts_low = 1'b0;
    repeat (4 * PF) @(negedge clk);

    // length zero means 256
    host_byte(8'h55, PF); host_byte(8'h00, PF);
    for (int i = 0; i < 256; i++) begin
      expect_rx(i == 255, 8'(i));
      host_byte(8'(i), PF);
    end
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all 256 bytes delivered", exp_q.size(), 0);

    // inter-byte timeout
    cfg_gap_limit = 16'd400;
    e0 = err_seen;
    expect_rx(0, 8'h10);
    host_byte(8'h55, PF); host_byte(8'h02, PF); host_byte(8'h10, PF);
    repeat (600) @(negedge clk);
    chk(err_seen - e0 == 1, "R5 timeout pulse", err_seen - e0, 1);
    expect_rx(1, 8'h20);
    host_byte(8'h55, PF); host_byte(8'h01, PF); host_byte(8'h20, PF);
    repeat (20) @(negedge clk);
    chk(err_seen - e0 == 1, "R5 no error on clean frame", err_seen - e0, 1);
    chk(exp_q.size() == 0, "R5 frame after abort", exp_q.size(), 0);

    // rts back-off, active-low polarity, stream hold
    rxd_ready = 1'b0;
    cfg_rts_low = 1'b1;
    host_byte(8'h55, PF); host_byte(8'h04, PF);
    for (int k = 1; k <= 4; k++) begin
      host_byte(8'hE0 + 8'(k - 1), PF);
      chk(uart_rts == ((k < DEPTH - 1) ? 1'b0 : 1'b1), "R7 rts level", uart_rts, (k < DEPTH - 1) ? 0 : 1);
    end
    chk(rxd_valid && rxd_data == 8'hE0 && !rxd_last, "R6 head held", {rxd_valid, rxd_data}, 9'h1E0);
    expect_rx(0, 8'hE0); expect_rx(0, 8'hE1); expect_rx(0, 8'hE2); expect_rx(1, 8'hE3);
    rxd_ready = 1'b1;
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R6 held bytes drained", exp_q.size(), 0);
    chk(uart_rts == 1'b0, "R7 rts active-low after drain", uart_rts, 0);
    cfg_rts_low = 1'b0;

    // slow autobaud after a new reset
    cfg_gap_limit = 16'd2000;
    do_reset();
    chk(baud_locked == 1'b0, "R1 unlocked after second reset", baud_locked, 0);
    host_byte(8'h55, PS);
    repeat (4) @(negedge clk);
    chk(baud_locked && !baud_fast, "R1 slow rate chosen", {baud_locked, baud_fast}, 2'b10);
    expect_rx(1, 8'h5A);
    host_byte(8'h01, PS); host_byte(8'h5A, PS);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R2 slow frame delivered", exp_q.size(), 0);
    chk(baud_locked && !baud_fast, "R12 lock kept", {baud_locked, baud_fast}, 2'b10);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule